// File: doc/BRIEF.md
# Double-Buffered Window Configuration Bank

This block keeps two copies of the configuration words for each window of a multi-window display controller: a staging copy that software writes, and a live copy that drives the scan-out logic. A write through the register port lands only in the staging copy. Staged values reach the live copy at a vertical sync strobe, and only for windows whose hold-off (protect) input is low and that were armed by an update request. A window's configuration can therefore be rewritten over several cycles without the scan-out ever seeing a half-written set.

An update request arms every window. At each vsync strobe, each armed window whose protect input is low copies its whole staging set into the live set and disarms itself. An armed window that is protected stays armed and copies at the first vsync after its protect input is released. Bit 0 of configuration word 0 of each window is that window's enable, so switching a layer off also waits for a vsync. A synchronous software reset clears both copies and all arming. Window 0 is intended as the primary layer and window 1 as a cursor layer; the window count is a parameter.

Top module: `shadow_bank`

## Requirements
- R1: A write (`wrEn` high, window `wrWin`, word `wrReg`, value `wrData`) changes only the staging copy; `activeCfg` and `winOn` do not change in any cycle without a vsync strobe.
- R2: At a clock edge with `vsync` high, every window with its `updPending` bit high and its `protect` bit low copies all its staging words into the live copy; the new values are visible right after that edge. Word r of window w occupies `activeCfg[((w*NUM_REG)+r)*DATA_W +: DATA_W]`.
- R3: A vsync strobe with no window armed leaves `activeCfg` unchanged.
- R4: While a window's `protect` bit is high, vsync does not copy its staging words and its `updPending` bit stays high; writes to that window's staging words are still accepted.
- R5: After a protected, armed window's `protect` bit falls, its staged values are copied at the next vsync, independently of other windows.
- R6: A one-cycle `updReq` pulse sets every `updPending` bit at the following edge; a bit clears at the edge where its window copies. An `updReq` in the same cycle as `vsync` does not cause a copy at that edge; it arms the next vsync.
- R7: `winOn[w]` equals bit 0 of live word 0 of window w; clearing that bit in the staging copy turns the window off only at the next armed, unprotected vsync.
- R8: `swRst` high at an edge clears every staging word, every live word and every `updPending` bit; it takes priority over writes, arming and copies.
- R9: The latest write to a staging word is the one copied; a write in the same cycle as a copy of its window is not part of that copy and is applied by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swRst | input | 1 | Synchronous software reset of both copies and arming |
| wrEn | input | 1 | Staging write strobe |
| wrWin | input | WIN_W | Window selected for the write |
| wrReg | input | REG_W | Word index within the window |
| wrData | input | DATA_W | Write value |
| updReq | input | 1 | Update request; arms all windows |
| vsync | input | 1 | Vertical sync strobe, one cycle |
| protect | input | NUM_WIN | Per-window copy hold-off |
| activeCfg | output | NUM_WIN*NUM_REG*DATA_W | Live configuration words, flattened |
| winOn | output | NUM_WIN | Per-window live enable |
| updPending | output | NUM_WIN | Per-window armed flag |

## Verification
A wrong arming bit shows at `updPending` in the cycle after the edge concerned, and at `activeCfg` no later than the next vsync, as a copy that happens too early, too late or not at all. A staging word holding the wrong value stays hidden until the next copy of its window; the bench therefore arms and strobes vsync after every group of writes so that each staging error reaches the live outputs within a few cycles. Protect and same-cycle corner cases are checked at the edge itself, because a copy taken one edge early differs from a correct one only in that cycle.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int SHB_MAX_WIN = 8;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic                   clr;   // clear staging and live copies
    logic [SHB_MAX_WIN-1:0] xfer;  // per-window staging-to-live copy
  } shb_strobe_t;
endpackage

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               swRst,
  input  logic               updReq,
  input  logic               vsync,
  input  logic [NUM_WIN-1:0] protect,
  output shb_strobe_t        strb,
  output logic [NUM_WIN-1:0] pending
);
  logic [NUM_WIN-1:0] xferVec;

  // copy only armed windows that are not held off
  assign xferVec = {NUM_WIN{vsync}} & pending & ~protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending <= '0;
    else if (swRst) pending <= '0;
    else            pending <= (pending & ~xferVec) | {NUM_WIN{updReq}};
  end

  always_comb begin
    strb = '0;
    strb.clr = swRst;
    strb.xfer[NUM_WIN-1:0] = xferVec;
  end
endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int NUM_REG = 4,
  parameter int DATA_W  = 32,
  localparam int WIN_W = $clog2(NUM_WIN),
  localparam int REG_W = $clog2(NUM_REG),
  localparam int WIN_BITS = NUM_REG * DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  shb_strobe_t                 strb,
  input  logic                        wrEn,
  input  logic [WIN_W-1:0]            wrWin,
  input  logic [REG_W-1:0]            wrReg,
  input  logic [DATA_W-1:0]           wrData,
  output logic [NUM_WIN*WIN_BITS-1:0] activeFlat,
  output logic [NUM_WIN-1:0]          winOn
);
  logic unusedXferBits;
  assign unusedXferBits = ^strb.xfer;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      logic [DATA_W-1:0] stageQ;
      logic [DATA_W-1:0] liveQ;
      logic              wrHit;

      assign wrHit = wrEn && (wrWin == WIN_W'(w)) && (wrReg == REG_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stageQ <= '0;
        else if (strb.clr) stageQ <= '0;
        else if (wrHit)    stageQ <= wrData;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             liveQ <= '0;
        else if (strb.clr)      liveQ <= '0;
        else if (strb.xfer[w])  liveQ <= stageQ;
      end

      assign activeFlat[(w*NUM_REG + r)*DATA_W +: DATA_W] = liveQ;
    end
    assign winOn[w] = g_reg[0].liveQ[0];
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int NUM_REG = 4,
  parameter int DATA_W  = 32,
  localparam int WIN_W = $clog2(NUM_WIN),
  localparam int REG_W = $clog2(NUM_REG)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              swRst,
  input  logic                              wrEn,
  input  logic [WIN_W-1:0]                  wrWin,
  input  logic [REG_W-1:0]                  wrReg,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic                              updReq,
  input  logic                              vsync,
  input  logic [NUM_WIN-1:0]                protect,
  output logic [NUM_WIN*NUM_REG*DATA_W-1:0] activeCfg,
  output logic [NUM_WIN-1:0]                winOn,
  output logic [NUM_WIN-1:0]                updPending
);
  shb_strobe_t strb;

  shadow_bank_ctrl #(.NUM_WIN(NUM_WIN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .swRst(swRst), .updReq(updReq),
    .vsync(vsync), .protect(protect), .strb(strb), .pending(updPending)
  );

  shadow_bank_dp #(.NUM_WIN(NUM_WIN), .NUM_REG(NUM_REG), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrEn(wrEn), .wrWin(wrWin),
    .wrReg(wrReg), .wrData(wrData), .activeFlat(activeCfg), .winOn(winOn)
  );
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int NUM_WIN = 2,
  parameter int NUM_REG = 4,
  parameter int DATA_W  = 32,
  localparam int WIN_BITS = NUM_REG * DATA_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        swRst,
  input logic                        updReq,
  input logic                        vsync,
  input logic [NUM_WIN-1:0]          protect,
  input logic [NUM_WIN*WIN_BITS-1:0] activeCfg,
  input logic [NUM_WIN-1:0]          updPending
);
  // R1, R3: live copy moves only on a vsync edge
  p_live_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync && !swRst) |=> $stable(activeCfg));

  // R8: software reset empties everything
  p_swrst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swRst |=> (activeCfg == '0 && updPending == '0));

  // R6: a request arms every window
  p_arm_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (updReq && !swRst) |=> (updPending == {NUM_WIN{1'b1}}));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R4: protected window keeps its live set and its arming
    p_protect_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && protect[w] && !swRst) |=> $stable(activeCfg[w*WIN_BITS +: WIN_BITS]));
    p_protect_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (updPending[w] && protect[w] && !swRst) |=> updPending[w]);
    // R6: arming clears once the copy is taken
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && updPending[w] && !protect[w] && !updReq && !swRst) |=> !updPending[w]);
  end
endmodule

bind shadow_bank shadow_bank_chk #(.NUM_WIN(NUM_WIN), .NUM_REG(NUM_REG), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .swRst(swRst), .updReq(updReq), .vsync(vsync),
  .protect(protect), .activeCfg(activeCfg), .updPending(updPending)
);

// File: tb/shadow_bank_tb_top.sv
module shadow_bank_tb_top;
  localparam int NW = 2;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int CFG_W = NW * NR * DW;

  logic clk = 0;
  logic rst_n = 0;
  logic swRst = 0, wrEn = 0, updReq = 0, vsync = 0;
  logic [0:0] wrWin = '0;
  logic [1:0] wrReg = '0;
  logic [DW-1:0] wrData = '0;
  logic [NW-1:0] protect = '0;
  logic [CFG_W-1:0] activeCfg;
  logic [NW-1:0] winOn, updPending;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_bank #(.NUM_WIN(NW), .NUM_REG(NR), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .swRst(swRst), .wrEn(wrEn), .wrWin(wrWin),
    .wrReg(wrReg), .wrData(wrData), .updReq(updReq), .vsync(vsync),
    .protect(protect), .activeCfg(activeCfg), .winOn(winOn), .updPending(updPending)
  );

  typedef struct {
    string            req;
    logic [CFG_W-1:0] cfg;
    logic [NW-1:0]    on;
    logic [NW-1:0]    pend;
  } exp_t;

  exp_t expQ[$];

  // bench model built from the requirements
  logic [DW-1:0] mStage [NW][NR];
  logic [DW-1:0] mLive  [NW][NR];
  logic [NW-1:0] mPend;

  function automatic logic [CFG_W-1:0] packLive();
    logic [CFG_W-1:0] v;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++)
        v[(w*NR + r)*DW +: DW] = mLive[w][r];
    return v;
  endfunction

  task automatic pushExp(input string req);
    exp_t e;
    e.req = req;
    e.cfg = packLive();
    for (int w = 0; w < NW; w++) e.on[w] = mLive[w][0][0];
    e.pend = mPend;
    expQ.push_back(e);
  endtask

  // one clock cycle of stimulus, model update, expectation
  task automatic doCycle(input logic wr, input int win, input int rg, input logic [DW-1:0] d,
                         input logic upd, input logic vs, input logic sw, input string req);
    logic [NW-1:0] cp;
    wrEn = wr; wrWin = win[0:0]; wrReg = rg[1:0]; wrData = d;
    updReq = upd; vsync = vs; swRst = sw;
    @(posedge clk);
    #1;
    wrEn = 0; updReq = 0; vsync = 0; swRst = 0;
    if (sw) begin
      for (int w = 0; w < NW; w++)
        for (int r = 0; r < NR; r++) begin mStage[w][r] = '0; mLive[w][r] = '0; end
      mPend = '0;
    end else begin
      cp = vs ? (mPend & ~protect) : '0;
      for (int w = 0; w < NW; w++)
        if (cp[w]) for (int r = 0; r < NR; r++) mLive[w][r] = mStage[w][r];
      if (wr) mStage[win][rg] = d;
      mPend = (mPend & ~cp) | (upd ? {NW{1'b1}} : '0);
    end
    pushExp(req);
  endtask

  task automatic idle(input string req);
    doCycle(0, 0, 0, '0, 0, 0, 0, req);
  endtask

  // monitor: compare queued expectations away from the edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (activeCfg !== e.cfg || winOn !== e.on || updPending !== e.pend) begin
          bad++;
          $display("FAIL %s: cfg=%h on=%b pend=%b expected cfg=%h on=%b pend=%b",
                   e.req, activeCfg, winOn, updPending, e.cfg, e.on, e.pend);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) begin mStage[w][r] = '0; mLive[w][r] = '0; end
    mPend = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle("R8 reset state");

    // R1: staged writes do not reach live copy
    doCycle(1, 0, 0, 32'h0000_0011, 0, 0, 0, "R1 write win0 w0");
    doCycle(1, 0, 1, 32'hA5A5_0001, 0, 0, 0, "R1 write win0 w1");
    doCycle(1, 1, 0, 32'h0000_0101, 0, 0, 0, "R1 write win1 w0");
    doCycle(1, 1, 3, 32'hDEAD_BEEF, 0, 0, 0, "R1 write win1 w3");
    // R3: vsync without arming
    doCycle(0, 0, 0, '0, 0, 1, 0, "R3 unarmed vsync");
    // R6 arm, R2/R7 copy
    doCycle(0, 0, 0, '0, 1, 0, 0, "R6 arm all");
    idle("R1 armed no vsync");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R2 R7 armed vsync copies");

    // R7: disable waits for vsync
    doCycle(1, 0, 0, 32'h0000_0010, 0, 0, 0, "R7 clear enable staged");
    doCycle(0, 0, 0, '0, 1, 0, 0, "R7 still on after arm");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R7 off at vsync");

    // R4: protect window 1
    protect = 2'b10;
    doCycle(1, 1, 2, 32'h1234_5678, 0, 0, 0, "R4 write to protected win1");
    doCycle(1, 0, 2, 32'h0BAD_F00D, 1, 0, 0, "R4 write win0 and arm");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R4 vsync copies win0 only");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R4 second vsync still held");
    // R5: release protect
    protect = 2'b00;
    idle("R5 released no vsync");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R5 copy after release");

    // R6: request coincident with vsync
    doCycle(1, 1, 1, 32'h7777_0000, 0, 0, 0, "R6 stage win1 w1");
    doCycle(0, 0, 0, '0, 1, 1, 0, "R6 same-cycle arm no copy");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R6 copy next vsync");

    // R9: last write wins, and write during copy
    doCycle(1, 0, 3, 32'h1111_1111, 0, 0, 0, "R9 first write");
    doCycle(1, 0, 3, 32'h2222_2222, 1, 0, 0, "R9 second write and arm");
    doCycle(1, 0, 3, 32'h3333_3333, 0, 1, 0, "R9 write during copy");
    doCycle(0, 0, 0, '0, 1, 0, 0, "R9 rearm");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R9 later write copied");

    // R8: software reset beats simultaneous write and arm
    doCycle(1, 1, 0, 32'hFFFF_FFFF, 1, 1, 1, "R8 software reset");
    doCycle(0, 0, 0, '0, 1, 0, 0, "R8 arm after reset");
    doCycle(0, 0, 0, '0, 0, 1, 0, "R8 staging was cleared");

    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule